// File: doc/BRIEF.md
# Conditional Add/Subtract Register Unit

This block holds two W-bit registers, an accumulator and an operand, and one shared adder between them. On each clock edge, with write-back enabled, the accumulator takes either the sum of both registers or the accumulator minus the operand. The subtract control does two jobs. It inverts every operand bit on its way into the adder, and it supplies the carry-in, so one adder covers both operations.

With write-back disabled, nothing is transferred. The carry and the signed overflow of the adder are registered as status outputs, together with the write-back. Direct load ports set either register, so a controller or a bench can place operands before the arithmetic runs.

Top module: `regxfer_addsub`

## Requirements
- R1: While rst_ni is low, acc_o, opnd_o, carry_o and ovf_o are all 0.
- R2: With wr_en_i=1, sub_i=0 and load_a_i=0, acc_o becomes (acc_o + opnd_o) mod 2^W on the next rising edge.
- R3: With wr_en_i=1, sub_i=1 and load_a_i=0, acc_o becomes (acc_o + ~opnd_o + 1) mod 2^W, the two's-complement difference, on the next rising edge.
- R4: With wr_en_i=0 and load_a_i=0, acc_o, carry_o and ovf_o keep their values across the edge, whatever sub_i is.
- R5: On a write-back, carry_o takes the carry out of bit W-1 of the adder. For addition this is 1 when the unsigned sum exceeds 2^W-1. For subtraction it is 1 exactly when acc_o >= opnd_o unsigned, meaning no borrow.
- R6: On a write-back, ovf_o is 1 exactly when the two's-complement result does not fit in W signed bits. For addition, both inputs have the same sign and the result sign differs. For subtraction, the input signs differ and the result sign differs from acc_o.
- R7: load_a_i=1 loads load_a_data_i into acc_o on the next edge and takes priority over write-back. In that cycle carry_o and ovf_o keep their values.
- R8: load_b_i=1 loads load_b_data_i into opnd_o on the next edge. A write-back in the same cycle uses the old operand value.
- R9: opnd_o changes only through load_b_i. Arithmetic never writes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sub_i | input | 1 | 0 selects add, 1 selects subtract |
| wr_en_i | input | 1 | Enables write-back of the adder result into the accumulator |
| load_a_i | input | 1 | Direct load of the accumulator |
| load_a_data_i | input | W | Accumulator load value |
| load_b_i | input | 1 | Direct load of the operand register |
| load_b_data_i | input | W | Operand load value |
| acc_o | output | W | Accumulator contents |
| opnd_o | output | W | Operand register contents |
| carry_o | output | 1 | Registered adder carry-out |
| ovf_o | output | 1 | Registered signed overflow |

## Verification
Directed corners separate the two flags from each other:
- 0x7F+0x01 sets overflow without carry.
- 0xFF+0x01 sets carry without overflow.
- 0x80-0x01 sets overflow on the subtract path.
- Equal operands in a subtraction must give carry 1, which shows that the carry-in really is the subtract control.
- Smaller-minus-larger must give carry 0.

Cycles with write-back off and sub_i toggling show that the subtract control alone changes nothing. Cycles that combine a load with a write-back tell the load priority apart from the same-edge operand update. Seeded random operands then mix adds, subtracts, holds and loads against a bench model that uses integer arithmetic.

// File: rtl/regxfer_pkg.sv
package regxfer_pkg;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } op_e;

  typedef struct packed {
    logic carry;
    logic ovf;
  } flags_t;

endpackage

// File: rtl/operand_cond.sv
module operand_cond
  import regxfer_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] b_i,
  input  op_e          op_i,
  output logic [W-1:0] b_o
);

  logic inv;
  assign inv = (op_i == OP_SUB);

  // one XOR per bit: conditional ones' complement
  for (genvar i = 0; i < W; i++) begin : g_xor
    assign b_o[i] = b_i[i] ^ inv;
  end

endmodule

// File: rtl/ripple_adder.sv
module ripple_adder #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         cmsb_o
);

  logic [W:0] c;
  assign c[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_fa
    logic p;
    assign p        = a_i[i] ^ b_i[i];
    assign sum_o[i] = p ^ c[i];
    assign c[i+1]   = (a_i[i] & b_i[i]) | (p & c[i]);
  end

  assign cout_o = c[W];
  assign cmsb_o = c[W-1];

endmodule

// File: rtl/status_calc.sv
module status_calc
  import regxfer_pkg::*;
(
  input  logic   cout_i,
  input  logic   cmsb_i,
  output flags_t flags_o
);

  // signed overflow: carry into msb differs from carry out of msb
  assign flags_o.carry = cout_i;
  assign flags_o.ovf   = cout_i ^ cmsb_i;

endmodule

// File: rtl/regxfer_addsub.sv
module regxfer_addsub
  import regxfer_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sub_i,
  input  logic         wr_en_i,
  input  logic         load_a_i,
  input  logic [W-1:0] load_a_data_i,
  input  logic         load_b_i,
  input  logic [W-1:0] load_b_data_i,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] opnd_o,
  output logic         carry_o,
  output logic         ovf_o
);

  localparam int unsigned MinW = 2;
  if (W < MinW) begin : g_bad_w
    $error("regxfer_addsub: W must be at least 2");
  end

  op_e          op;
  logic [W-1:0] acc_q, opnd_q, opnd_c, sum;
  logic         cout, cmsb;
  flags_t       flags_d, flags_q;

  assign op = op_e'(sub_i);

  operand_cond #(.W(W)) u_cond (
    .b_i  (opnd_q),
    .op_i (op),
    .b_o  (opnd_c)
  );

  // sub_i doubles as carry-in: +1 completes the two's complement
  ripple_adder #(.W(W)) u_add (
    .a_i    (acc_q),
    .b_i    (opnd_c),
    .cin_i  (sub_i),
    .sum_o  (sum),
    .cout_o (cout),
    .cmsb_o (cmsb)
  );

  status_calc u_stat (
    .cout_i  (cout),
    .cmsb_i  (cmsb),
    .flags_o (flags_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      flags_q <= '0;
    end else if (load_a_i) begin
      acc_q   <= load_a_data_i;
    end else if (wr_en_i) begin
      acc_q   <= sum;
      flags_q <= flags_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       opnd_q <= '0;
    else if (load_b_i) opnd_q <= load_b_data_i;
  end

  assign acc_o   = acc_q;
  assign opnd_o  = opnd_q;
  assign carry_o = flags_q.carry;
  assign ovf_o   = flags_q.ovf;

endmodule

// File: rtl/regxfer_addsub_chk.sv
module regxfer_addsub_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         sub_i,
  input logic         wr_en_i,
  input logic         load_a_i,
  input logic [W-1:0] load_a_data_i,
  input logic         load_b_i,
  input logic [W-1:0] load_b_data_i,
  input logic [W-1:0] acc_o,
  input logic [W-1:0] opnd_o,
  input logic         carry_o,
  input logic         ovf_o
);

  logic [W:0] ref_sum, ref_diff;
  logic       ref_ovf_add, ref_ovf_sub, ref_ovf;

  assign ref_sum     = {1'b0, acc_o} + {1'b0, opnd_o};
  assign ref_diff    = {1'b0, acc_o} - {1'b0, opnd_o};
  assign ref_ovf_add = (acc_o[W-1] == opnd_o[W-1]) && (ref_sum[W-1] != acc_o[W-1]);
  assign ref_ovf_sub = (acc_o[W-1] != opnd_o[W-1]) && (ref_diff[W-1] != acc_o[W-1]);
  assign ref_ovf     = sub_i ? ref_ovf_sub : ref_ovf_add;

  always_comb begin
    if (!rst_ni) begin
      assert_reset_R1: assert (acc_o == '0 && opnd_o == '0 && !carry_o && !ovf_o);
    end
  end

  assert_add_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !sub_i && !load_a_i |=> acc_o == $past(ref_sum[W-1:0]));

  assert_sub_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && sub_i && !load_a_i |=> acc_o == $past(ref_diff[W-1:0]));

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i && !load_a_i |=> $stable(acc_o) && $stable(carry_o) && $stable(ovf_o));

  assert_carry_add_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !sub_i && !load_a_i |=> carry_o == $past(ref_sum[W]));

  assert_carry_sub_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && sub_i && !load_a_i |=> carry_o == $past(acc_o >= opnd_o));

  assert_ovf_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !load_a_i |=> ovf_o == $past(ref_ovf));

  assert_load_a_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_a_i |=> acc_o == $past(load_a_data_i) && $stable(carry_o) && $stable(ovf_o));

  assert_load_b_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_b_i |=> opnd_o == $past(load_b_data_i));

  assert_opnd_keep_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_b_i |=> $stable(opnd_o));

endmodule

bind regxfer_addsub regxfer_addsub_chk #(.W(W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sub_i         (sub_i),
  .wr_en_i       (wr_en_i),
  .load_a_i      (load_a_i),
  .load_a_data_i (load_a_data_i),
  .load_b_i      (load_b_i),
  .load_b_data_i (load_b_data_i),
  .acc_o         (acc_o),
  .opnd_o        (opnd_o),
  .carry_o       (carry_o),
  .ovf_o         (ovf_o)
);

// File: tb/regxfer_addsub_test.sv
module regxfer_addsub_test;

  localparam int W    = 8;
  localparam int SMAX = (1 << (W - 1)) - 1;
  localparam int SMIN = -(1 << (W - 1));

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         sub_i = 1'b0, wr_en_i = 1'b0, load_a_i = 1'b0, load_b_i = 1'b0;
  logic [W-1:0] load_a_data_i = '0, load_b_data_i = '0;
  logic [W-1:0] acc_o, opnd_o;
  logic         carry_o, ovf_o;

  logic [W-1:0] m_acc = '0, m_opnd = '0;
  logic         m_c = 1'b0, m_v = 1'b0;
  int           checks = 0, fails = 0;
  bit           done = 0;

  always #2 clk_i = ~clk_i;

  regxfer_addsub #(.W(W)) uut (
    .clk_i, .rst_ni, .sub_i, .wr_en_i, .load_a_i, .load_a_data_i,
    .load_b_i, .load_b_data_i, .acc_o, .opnd_o, .carry_o, .ovf_o
  );

  function automatic int sval(logic [W-1:0] v);
    return int'($signed(v));
  endfunction

  task automatic check(string req);
    checks++;
    if (acc_o !== m_acc || opnd_o !== m_opnd || carry_o !== m_c || ovf_o !== m_v) begin
      fails++;
      $display("FAIL %s: got acc=%h opnd=%h c=%b v=%b, expected acc=%h opnd=%h c=%b v=%b",
               req, acc_o, opnd_o, carry_o, ovf_o, m_acc, m_opnd, m_c, m_v);
    end
  endtask

  // drive at negedge, model the edge, compare at the following negedge
  task automatic step(input logic sub, input logic wr, input logic la, input logic [W-1:0] lad,
                      input logic lb, input logic [W-1:0] lbd, input string req);
    int r, s;
    sub_i = sub; wr_en_i = wr; load_a_i = la; load_a_data_i = lad;
    load_b_i = lb; load_b_data_i = lbd;
    @(posedge clk_i);
    if (la) m_acc = lad;
    else if (wr) begin
      if (!sub) begin
        r = int'(m_acc) + int'(m_opnd);
        s = sval(m_acc) + sval(m_opnd);
        m_c = (r >= (1 << W));
      end else begin
        r = int'(m_acc) - int'(m_opnd);
        s = sval(m_acc) - sval(m_opnd);
        m_c = (m_acc >= m_opnd);
      end
      m_v = (s > SMAX) || (s < SMIN);
      m_acc = W'(r);
    end
    if (lb) m_opnd = lbd;
    @(negedge clk_i);
    check(req);
  endtask

  task automatic setup(input logic [W-1:0] a, input logic [W-1:0] b);
    step(1'b0, 1'b0, 1'b1, a, 1'b1, b, "R7 setup");
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    check("R1 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release");

    setup(8'h7F, 8'h01); step(1'b0, 1'b1, 1'b0, '0, 1'b0, '0, "R6 add ovf no carry");
    setup(8'hFF, 8'h01); step(1'b0, 1'b1, 1'b0, '0, 1'b0, '0, "R5 add carry no ovf");
    setup(8'h35, 8'h12); step(1'b0, 1'b1, 1'b0, '0, 1'b0, '0, "R2 plain add");
    setup(8'h05, 8'h05); step(1'b1, 1'b1, 1'b0, '0, 1'b0, '0, "R3 R5 equal sub carry=1");
    setup(8'h03, 8'h05); step(1'b1, 1'b1, 1'b0, '0, 1'b0, '0, "R5 borrow carry=0");
    setup(8'h80, 8'h01); step(1'b1, 1'b1, 1'b0, '0, 1'b0, '0, "R6 sub ovf");
    step(1'b1, 1'b0, 1'b0, '0, 1'b0, '0, "R4 hold sub=1");
    step(1'b0, 1'b0, 1'b0, '0, 1'b0, '0, "R4 hold sub=0");
    step(1'b0, 1'b1, 1'b1, 8'hA5, 1'b0, '0, "R7 load beats write-back");
    step(1'b0, 1'b1, 1'b0, '0, 1'b1, 8'h40, "R8 same-edge uses old operand");
    step(1'b1, 1'b1, 1'b0, '0, 1'b0, '0, "R9 operand untouched by arithmetic");

    void'($urandom(32'h5EED));
    for (int i = 0; i < 400; i++) begin
      logic sub, wr, la, lb;
      logic [W-1:0] da, db;
      sub = 1'($urandom); wr = ($urandom % 4) != 0;
      la = ($urandom % 6) == 0; lb = ($urandom % 4) == 0;
      da = W'($urandom); db = W'($urandom);
      if (la)       step(sub, wr, la, da, lb, db, "R7 random load");
      else if (!wr) step(sub, wr, la, da, lb, db, "R4 R9 random hold");
      else if (sub) step(sub, wr, la, da, lb, db, "R3 R5 R6 R8 random sub");
      else          step(sub, wr, la, da, lb, db, "R2 R5 R6 R8 random add");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule